// File: doc/BRIEF.md
# Eight-Point Multiplierless DCT Engine

This block computes a one-dimensional eight-point discrete cosine transform without any multiplier. A vector of eight signed 16-bit samples is streamed in over a valid/ready input, one sample per accepted handshake. Once the eighth sample is captured, a butterfly register stage folds the vector into four mirrored sums and four mirrored differences. These are 17 bits wide, so the folding cannot overflow.

Each of the eight outputs has its own lane. A lane holds a 16-entry table of precomputed coefficient-row sums in fixed point with 12 fractional bits. It walks its four operands bit-serially, most significant (sign) bit first. The four bits at the current position form the table address. The first table word is negated. Each later word is added to the running sum after that sum is doubled. The 17-bit operands therefore take 17 cycles per vector.

The eight results leave on a valid/ready output together with a one-cycle completion pulse. No new sample is accepted until that output has been taken. A synchronous clear input abandons whatever vector is in progress. The block is meant to be the row pass of a separable 2-D transform. Rescaling, rounding and the column pass belong to the surrounding logic.

Top module: `da_dct8`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: Exactly eight samples are accepted per vector, one per cycle in which in_valid and in_ready are both 1. in_ready drops after the eighth and stays 0 until the results are taken.
- R3: Even output X(2r), for r = 0..3, sits at bits [64r+31:64r] of out_coefs as a signed 32-bit value. With s_i = x_i + x_(7-i), it equals the dot product of (s0,s1,s2,s3) with these rows: r=0 (A,A,A,A), r=1 (B,C,-C,-B), r=2 (A,-A,-A,A), r=3 (C,-B,B,-C). The constants are A=2896, B=3784 and C=1567.
- R4: Odd output X(2r+1) sits at bits [64r+63:64r+32] as a signed 32-bit value. With d_i = x_i - x_(7-i), it equals the dot product of (d0,d1,d2,d3) with these rows: r=0 (D,E,F,G), r=1 (E,-G,-D,-F), r=2 (F,-D,G,E), r=3 (G,-F,E,-D). The constants are D=4017, E=3406, F=2276 and G=799.
- R5: out_valid rises exactly 18 clock edges after the edge that accepts the eighth sample: one butterfly cycle, then 17 bit-serial cycles.
- R6: done is 1 only in the first cycle of each out_valid period, for exactly one cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid and out_coefs hold steady. out_valid falls on the edge where out_ready is 1, and in_ready returns to 1.
- R8: A clear (clr=1 at an edge) discards a partly loaded vector or a vector in computation. After that edge, in_ready is 1 and out_valid is 0, and the next eight accepted samples form a fresh vector.
- R9: in_valid and in_sample have no effect while in_ready is 0. Samples offered during computation change neither that vector's results nor the next vector.
- R10: Full-scale inputs cause no overflow. Mirrored sums down to -65536 and differences up to 65535 produce the exact R3/R4 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous abort of the current vector |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_sample | input | 16 | Signed sample, x0 first |
| out_valid | output | 1 | out_coefs holds a finished vector |
| out_ready | input | 1 | Consumer takes the vector |
| done | output | 1 | One-cycle pulse when a vector completes |
| out_coefs | output | 256 | Eight signed 32-bit results, X0 in the low bits |

## Verification
The hardest situations to reach from the ports are the table entries whose sign-bit word is negated while the mirrored sum or difference sits at the 17-bit extremes. Reaching them takes inputs at full scale and of opposite signs. A dedicated vector puts -32768 on both x0 and x7, and 32767 against -32768 on x1 and x6, so that both folds hit their limits. The other awkward cases are an abort landing mid-computation and samples offered while the block is busy. The bench times a clear a few cycles into the serial phase, and it drives a constant junk sample with in_valid high throughout the serial phase before checking the next vector.

// File: rtl/da_dct8_pkg.sv
package da_dct8_pkg;

  // Q12 coefficient constants
  localparam int CK_A = 2896;
  localparam int CK_B = 3784;
  localparam int CK_C = 1567;
  localparam int CK_D = 4017;
  localparam int CK_E = 3406;
  localparam int CK_F = 2276;
  localparam int CK_G = 799;

  typedef enum logic [1:0] {
    ST_LOAD   = 2'd0,
    ST_BFLY   = 2'd1,
    ST_SERIAL = 2'd2,
    ST_OUT    = 2'd3
  } dct_state_e;

  // coefficient of operand col in row row; odd selects the difference matrix
  function automatic int dct_coef(input int odd, input int row, input int col);
    int c;
    c = 0;
    if (odd == 0) begin
      case (row)
        0: c = CK_A;
        1: case (col) 0: c = CK_B; 1: c = CK_C; 2: c = -CK_C; default: c = -CK_B; endcase
        2: c = (col == 0 || col == 3) ? CK_A : -CK_A;
        default: case (col) 0: c = CK_C; 1: c = -CK_B; 2: c = CK_B; default: c = -CK_C; endcase
      endcase
    end else begin
      case (row)
        0: case (col) 0: c = CK_D; 1: c = CK_E; 2: c = CK_F; default: c = CK_G; endcase
        1: case (col) 0: c = CK_E; 1: c = -CK_G; 2: c = -CK_D; default: c = -CK_F; endcase
        2: case (col) 0: c = CK_F; 1: c = -CK_D; 2: c = CK_G; default: c = CK_E; endcase
        default: case (col) 0: c = CK_G; 1: c = -CK_F; 2: c = CK_E; default: c = -CK_D; endcase
      endcase
    end
    return c;
  endfunction

  // table word: operand k drives address bit 3-k
  function automatic int dct_rom_word(input int odd, input int row, input logic [3:0] addr);
    int w;
    w = 0;
    for (int k = 0; k < 4; k++) begin
      if (addr[3-k]) w = w + dct_coef(odd, row, k);
    end
    return w;
  endfunction

endpackage

// File: rtl/da_dct8_inbuf.sv
module da_dct8_inbuf #(
  parameter int SAMPLE_W = 16,
  parameter int NPTS     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [SAMPLE_W-1:0]        wr_data,
  output logic                       last_slot,
  output logic [NPTS*SAMPLE_W-1:0]   samples
);
  localparam int CNT_W = $clog2(NPTS);

  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [SAMPLE_W-1:0] slot_q [NPTS];

  always_comb begin
    cnt_d = cnt_q;
    if (clr)        cnt_d = '0;
    else if (wr_en) cnt_d = (cnt_q == CNT_W'(NPTS-1)) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) slot_q[cnt_q] <= wr_data;
  end

  assign last_slot = (cnt_q == CNT_W'(NPTS-1));

  for (genvar g = 0; g < NPTS; g++) begin : g_pack
    assign samples[g*SAMPLE_W +: SAMPLE_W] = slot_q[g];
  end
endmodule

// File: rtl/da_dct8_bfly.sv
module da_dct8_bfly #(
  parameter int SAMPLE_W = 16,
  parameter int NPTS     = 8
) (
  input  logic                            clk,
  input  logic                            load_en,
  input  logic [NPTS*SAMPLE_W-1:0]        samples,
  output logic [(NPTS/2)*(SAMPLE_W+1)-1:0] sums,
  output logic [(NPTS/2)*(SAMPLE_W+1)-1:0] difs
);
  localparam int HALF = NPTS / 2;
  localparam int OP_W = SAMPLE_W + 1;

  for (genvar g = 0; g < HALF; g++) begin : g_pair
    logic [SAMPLE_W-1:0] lo, hi;
    logic [OP_W-1:0]     lo_x, hi_x, sum_d, dif_d, sum_q, dif_q;

    assign lo    = samples[g*SAMPLE_W +: SAMPLE_W];
    assign hi    = samples[(NPTS-1-g)*SAMPLE_W +: SAMPLE_W];
    assign lo_x  = {lo[SAMPLE_W-1], lo};
    assign hi_x  = {hi[SAMPLE_W-1], hi};
    assign sum_d = lo_x + hi_x;
    assign dif_d = lo_x - hi_x;

    always_ff @(posedge clk) begin
      if (load_en) begin
        sum_q <= sum_d;
        dif_q <= dif_d;
      end
    end

    assign sums[g*OP_W +: OP_W] = sum_q;
    assign difs[g*OP_W +: OP_W] = dif_q;
  end
endmodule

// File: rtl/da_dct8_lane.sv
module da_dct8_lane
  import da_dct8_pkg::*;
#(
  parameter int ODD   = 0,
  parameter int ROW   = 0,
  parameter int OP_W  = 17,
  parameter int ACC_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_clr,
  input  logic                   step_en,
  input  logic                   first_step,
  input  logic [$clog2(OP_W)-1:0] bitpos,
  input  logic [4*OP_W-1:0]      ops,
  output logic [ACC_W-1:0]       acc
);
  localparam int NWORDS = 16;

  logic [OP_W-1:0]         op_arr  [4];
  logic signed [ACC_W-1:0] rom_tbl [NWORDS];
  logic [3:0]              addr;
  logic signed [ACC_W-1:0] word;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  for (genvar g = 0; g < 4; g++) begin : g_ops
    assign op_arr[g] = ops[g*OP_W +: OP_W];
  end

  for (genvar a = 0; a < NWORDS; a++) begin : g_rom
    assign rom_tbl[a] = ACC_W'(dct_rom_word(ODD, ROW, 4'(a)));
  end

  always_comb begin
    for (int k = 0; k < 4; k++) addr[3-k] = op_arr[k][bitpos];
  end

  assign word = rom_tbl[addr];

  always_comb begin
    acc_d = acc_q;
    if (acc_clr)      acc_d = '0;
    else if (step_en) acc_d = first_step ? -word : (acc_q <<< 1) + word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/da_dct8_ctrl.sv
module da_dct8_ctrl
  import da_dct8_pkg::*;
#(
  parameter int OP_W = 17
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    in_valid,
  input  logic                    last_slot,
  input  logic                    out_ready,
  output logic                    in_ready,
  output logic                    bfly_en,
  output logic                    acc_clr,
  output logic                    step_en,
  output logic                    first_step,
  output logic [$clog2(OP_W)-1:0] bitpos,
  output logic                    out_valid,
  output logic                    done
);
  localparam int BP_W = $clog2(OP_W);
  localparam logic [BP_W-1:0] BP_TOP = BP_W'(OP_W-1);

  dct_state_e      state_q, state_d;
  logic [BP_W-1:0] bp_q, bp_d;
  logic            done_q, done_d;

  always_comb begin
    state_d  = state_q;
    bp_d     = bp_q;
    done_d   = 1'b0;
    in_ready = 1'b0;
    bfly_en  = 1'b0;
    acc_clr  = 1'b0;
    step_en  = 1'b0;
    case (state_q)
      ST_LOAD: begin
        in_ready = 1'b1;
        if (in_valid && last_slot) state_d = ST_BFLY;
      end
      ST_BFLY: begin
        bfly_en = 1'b1;
        acc_clr = 1'b1;
        bp_d    = BP_TOP;
        state_d = ST_SERIAL;
      end
      ST_SERIAL: begin
        step_en = 1'b1;
        if (bp_q == '0) begin
          state_d = ST_OUT;
          done_d  = 1'b1;
        end else begin
          bp_d = bp_q - 1'b1;
        end
      end
      default: begin
        if (out_ready) state_d = ST_LOAD;
      end
    endcase
    if (clr) begin
      state_d = ST_LOAD;
      bp_d    = BP_TOP;
      done_d  = 1'b0;
      acc_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOAD;
      bp_q    <= BP_TOP;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bp_q    <= bp_d;
      done_q  <= done_d;
    end
  end

  assign first_step = (state_q == ST_SERIAL) && (bp_q == BP_TOP);
  assign bitpos     = bp_q;
  assign out_valid  = (state_q == ST_OUT);
  assign done       = done_q;
endmodule

// File: rtl/da_dct8.sv
module da_dct8
  import da_dct8_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ACC_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                done,
  output logic [8*ACC_W-1:0]  out_coefs
);
  localparam int NPTS = 8;
  localparam int HALF = NPTS / 2;
  localparam int OP_W = SAMPLE_W + 1;
  localparam int BP_W = $clog2(OP_W);

  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic                      wr_en, last_slot;
  logic [NPTS*SAMPLE_W-1:0]  samples;
  logic [HALF*OP_W-1:0]      sums, difs;
  logic                      bfly_en, acc_clr, step_en, first_step;
  logic [BP_W-1:0]           bitpos;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_en = in_valid && in_ready;

  da_dct8_inbuf #(.SAMPLE_W(SAMPLE_W), .NPTS(NPTS)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (clr),
    .wr_en     (wr_en),
    .wr_data   (in_sample),
    .last_slot (last_slot),
    .samples   (samples)
  );

  da_dct8_bfly #(.SAMPLE_W(SAMPLE_W), .NPTS(NPTS)) u_bfly (
    .clk     (clk),
    .load_en (bfly_en),
    .samples (samples),
    .sums    (sums),
    .difs    (difs)
  );

  da_dct8_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .clr        (clr),
    .in_valid   (in_valid),
    .last_slot  (last_slot),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .bfly_en    (bfly_en),
    .acc_clr    (acc_clr),
    .step_en    (step_en),
    .first_step (first_step),
    .bitpos     (bitpos),
    .out_valid  (out_valid),
    .done       (done)
  );

  // lane k: even k uses the sums, odd k the differences; row k/2
  for (genvar k = 0; k < NPTS; k++) begin : g_lane
    logic [ACC_W-1:0] lane_acc;
    da_dct8_lane #(
      .ODD   (k % 2),
      .ROW   (k / 2),
      .OP_W  (OP_W),
      .ACC_W (ACC_W)
    ) u_lane (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .acc_clr    (acc_clr),
      .step_en    (step_en),
      .first_step (first_step),
      .bitpos     (bitpos),
      .ops        ((k % 2) ? difs : sums),
      .acc        (lane_acc)
    );
    assign out_coefs[k*ACC_W +: ACC_W] = lane_acc;
  end
endmodule

// File: rtl/da_dct8_chk.sv
module da_dct8_chk #(
  parameter int ACC_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic               done,
  input logic [8*ACC_W-1:0] out_coefs
);
  logic [2:0] acc_cnt;
  logic       run;
  logic [5:0] lat;

  // latency window kept by counter rather than a long delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt <= '0;
      run     <= 1'b0;
      lat     <= '0;
    end else if (clr) begin
      acc_cnt <= '0;
      run     <= 1'b0;
      lat     <= '0;
    end else begin
      if (in_valid && in_ready) acc_cnt <= acc_cnt + 1'b1;
      if (in_valid && in_ready && acc_cnt == 3'd7) begin
        run <= 1'b1;
        lat <= '0;
      end else if (out_valid) begin
        run <= 1'b0;
      end else if (run && lat != 6'h3f) begin
        lat <= lat + 1'b1;
      end
    end
  end

  assert_busy_blocks_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (run && lat == 6'd18));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid);

  assert_hold_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_coefs)));

  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (in_ready && !out_valid));
endmodule

bind da_dct8 da_dct8_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .done      (done),
  .out_coefs (out_coefs)
);

// File: tb/da_dct8_tb.sv
`timescale 1ns/1ps
module da_dct8_tb;
  logic         clk = 1'b0;
  logic         rst_n, clr, in_valid, out_ready;
  logic [15:0]  in_sample;
  logic         in_ready, out_valid, done;
  logic [255:0] out_coefs;

  int errors = 0;
  int checks = 0;
  int cf [8][4];
  int vec [8];

  always #2.5 clk = ~clk;

  da_dct8 u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .done(done), .out_coefs(out_coefs)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint expect_k(input int k);
    longint s = 0;
    for (int i = 0; i < 4; i++) begin
      longint u;
      u = (k % 2) ? longint'(vec[i]) - longint'(vec[7-i]) : longint'(vec[i]) + longint'(vec[7-i]);
      s += longint'(cf[k][i]) * u;
    end
    return s;
  endfunction

  function automatic longint got_k(input int k);
    logic [31:0] w;
    w = out_coefs[k*32 +: 32];
    return longint'($signed(w));
  endfunction

  task automatic check_outputs(input string tag);
    for (int k = 0; k < 8; k++)
      chk(got_k(k) == expect_k(k), (k % 2) ? "R4" : "R3",
          $sformatf("%s X%0d", tag, k), got_k(k), expect_k(k));
  endtask

  task automatic load_vec();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b1, "R2", $sformatf("in_ready before sample %0d", i), in_ready, 1);
      in_valid  = 1'b1;
      in_sample = 16'(vec[i]);
      @(posedge clk);
    end
  endtask

  // wait from the eighth accept edge; optional junk offered while busy (R9)
  task automatic wait_result(input string tag, input bit noise, input bit hold);
    int n = 0;
    bit first = 1'b1;
    forever begin
      @(negedge clk);
      if (first) begin
        first = 1'b0;
        chk(in_ready == 1'b0, "R2", {tag, " in_ready after eighth"}, in_ready, 0);
      end
      in_valid  = noise;
      in_sample = 16'h7abc;
      if (out_valid || n > 60) break;
      @(posedge clk);
      n++;
    end
    in_valid = 1'b0;
    chk(n == 18, "R5", {tag, " latency"}, n, 18);
    chk(done == 1'b1, "R6", {tag, " done on first valid cycle"}, done, 1);
    check_outputs(tag);
    if (hold) begin
      repeat (3) begin
        @(negedge clk);
        chk(done == 1'b0, "R6", {tag, " done drops"}, done, 0);
        chk(out_valid == 1'b1 && in_ready == 1'b0, "R7", {tag, " valid held"}, out_valid, 1);
      end
      check_outputs({tag, " held"});
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R7", {tag, " valid after take"}, out_valid, 0);
    chk(in_ready == 1'b1, "R7", {tag, " ready after take"}, in_ready, 1);
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    in_valid = 1'b0;
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R8", "idle after clear", in_ready, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < 8; i++) vec[i] = 100 * (i + 1);
    load_vec();
    wait_result("ramp", 1'b0, 1'b1);
  endtask

  task automatic t_flat();
    for (int i = 0; i < 8; i++) vec[i] = -1234;
    load_vec();
    wait_result("flat", 1'b0, 1'b0);
  endtask

  task automatic t_full_scale();
    vec = '{-32768, 32767, -32768, 1, -5, 32767, -32768, -32768};
    load_vec();
    wait_result("R10 full-scale", 1'b0, 1'b0);
    vec = '{32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768};
    load_vec();
    wait_result("R10 alternating", 1'b0, 1'b1);
  endtask

  task automatic t_busy_input();
    vec = '{-7, 3021, -15000, 42, 9999, -1, 250, -32000};
    load_vec();
    wait_result("R9 busy junk", 1'b1, 1'b1);
    vec = '{5, -6, 7, -8, 9, -10, 11, -12};
    load_vec();
    wait_result("R9 next vector", 1'b0, 1'b0);
  endtask

  task automatic t_clear_load();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sample = 16'h4444;
      @(posedge clk);
    end
    pulse_clr();
    vec = '{11, 22, 33, 44, -55, -66, -77, -88};
    load_vec();
    wait_result("R8 after load clear", 1'b0, 1'b0);
  endtask

  task automatic t_clear_serial();
    vec = '{900, 800, 700, 600, 500, 400, 300, 200};
    load_vec();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    pulse_clr();
    begin
      bit seen = 1'b0;
      repeat (25) begin
        @(negedge clk);
        if (out_valid || !in_ready) seen = 1'b1;
      end
      chk(seen == 1'b0, "R8", "no result after serial clear", seen, 0);
    end
    vec = '{-300, 120, 0, 77, -77, 0, -120, 300};
    load_vec();
    wait_result("R8 after serial clear", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R5 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cf[0] = '{2896, 2896, 2896, 2896};
    cf[2] = '{3784, 1567, -1567, -3784};
    cf[4] = '{2896, -2896, -2896, 2896};
    cf[6] = '{1567, -3784, 3784, -1567};
    cf[1] = '{4017, 3406, 2276, 799};
    cf[3] = '{3406, -799, -4017, -2276};
    cf[5] = '{2276, -4017, 799, 3406};
    cf[7] = '{799, -2276, 3406, -4017};
    rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_sample = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    t_reset();
    t_ramp();
    t_flat();
    t_full_scale();
    t_busy_input();
    t_clear_load();
    t_clear_serial();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule